// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns an 18-bit parallel word into a 20-bit serial frame on a single line. Each frame opens with a fixed high clock bit and closes with a fixed low clock bit, so the high-to-low pair forms a guaranteed edge that a receiver can use to recover the clock from the stream itself. The block runs from a bit clock at twenty times the word rate. A one-cycle word strobe captures the parallel input into a holding register. The word captured during one frame is sent in the following frame, and the holding register is resent until a new word arrives.

A sync request replaces the payload with a training word: nine ones on the first nine payload slots and nine zeros on the last nine. Each request produces a burst of at least six training frames. The serial line has a companion output-enable flag that stands in for a high-impedance driver. The flag drops at once when the driver enable is low, and it also drops during power-down. After reset, or after power-down is released, the flag stays low for a fixed number of frame periods. This interval models the clock-ready delay of the multiplying clock source.

Top module: `ser_embed_clk`

## Requirements
- R1: Every frame occupies 20 consecutive bit clocks; slot 0 (first on the line) is always 1 and slot 19 (last) is always 0.
- R2: Payload bit k of the word is sent in slot k+1, so bit 0 goes out right after the opening 1 and bit 17 goes out just before the closing 0.
- R3: A word captured by `word_stb_i` during one frame is sent in the next frame; frames with no new capture repeat the last captured word.
- R4: While `sync_i` is high, `word_stb_i` captures nothing; a frame that begins while a sync request is seen carries payload 1 in slots 1 to 9 and 0 in slots 10 to 18.
- R5: Each frame boundary at which `sync_i` is high starts a run of 6 training frames; data frames resume only after 6 training frames have followed the last such boundary.
- R6: With `den_i` low, `oe_o` is low in the same cycle, while frame timing keeps running; when `den_i` returns high, the line resumes on the same frame grid.
- R7: With `pwr_ni` low, `oe_o` is low in the same cycle, frame timing stops, and strobes are ignored; the held word survives.
- R8: After reset release or power-down release, `oe_o` stays low for exactly 1024 frame periods (20480 bit clocks) and first rises on slot 0 of a frame.
- R9: `ser_o` is 0 whenever `oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, 20 times the word rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 18 | Parallel word |
| word_stb_i | input | 1 | One-cycle capture strobe for `data_i` |
| sync_i | input | 1 | Request for training frames |
| den_i | input | 1 | Line driver enable, active high |
| pwr_ni | input | 1 | Power-down, active low |
| ser_o | output | 1 | Serial line |
| oe_o | output | 1 | Line driven flag; low stands for high impedance |

## Verification
The hardest states to reach are those that fall between frame boundaries. Examples are a driver enable that drops and returns in the middle of a frame, and a strobe that lands while a sync request is active. The stimulus keeps its own bit-slot count from the first rise of `oe_o` and changes inputs only at a fixed slot inside a frame. This lets it check partial frames slot by slot and confirm that the grid did not move. It also lets it check that a word strobed during sync or during power-down never reaches the line. The long clock-ready interval is timed in full, both after reset and after a power-down, by counting bit clocks until the flag rises.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;
  localparam logic OPEN_LVL  = 1'b1;
  localparam logic CLOSE_LVL = 1'b0;

  typedef enum logic {SRC_WORD, SRC_TRAIN} payload_src_e;
endpackage

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
  parameter int unsigned FRAME_W = 20,
  localparam int unsigned SW = $clog2(FRAME_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic          wrap_o,
  output logic [SW-1:0] slot_o
);
  logic [SW-1:0] slot_q;

  assign wrap_o = run_i && (slot_q == SW'(FRAME_W - 1));
  assign slot_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= '0;
    else if (!run_i)  slot_q <= '0;
    else if (wrap_o)  slot_q <= '0;
    else              slot_q <= slot_q + 1'b1;
  end
endmodule

// File: rtl/ser_ready_timer.sv
module ser_ready_timer #(
  parameter int unsigned READY_WORDS = 1024,
  localparam int unsigned RW = (READY_WORDS > 1) ? $clog2(READY_WORDS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wrap_i,
  output logic ready_o
);
  logic [RW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (wrap_i && !rdy_q) begin
      if (cnt_q == RW'(READY_WORDS - 1)) rdy_q <= 1'b1;
      else                               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/ser_payload_sel.sv
module ser_payload_sel
  import ser_frame_pkg::*;
#(
  parameter int unsigned DATA_W   = 18,
  parameter int unsigned SYNC_MIN = 6,
  localparam int unsigned LW = $clog2(SYNC_MIN + 1),
  localparam logic [DATA_W-1:0] TRAIN =
    {{(DATA_W - DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wrap_i,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sync_i,
  output logic [DATA_W-1:0] payload_o
);
  logic [DATA_W-1:0] hold_q;
  logic [LW-1:0]     left_q;
  payload_src_e      src;

  // sync seen now or a training burst still owed
  assign src       = (sync_i || left_q != '0) ? SRC_TRAIN : SRC_WORD;
  assign payload_o = (src == SRC_TRAIN) ? TRAIN : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hold_q <= '0;
    else if (run_i && stb_i && !sync_i) hold_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      left_q <= '0;
    else if (!run_i)                  left_q <= '0;
    else if (wrap_i) begin
      if (sync_i)                     left_q <= LW'(SYNC_MIN - 1);
      else if (left_q != '0)          left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_frame_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  localparam int unsigned FRAME_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wrap_i,
  input  logic [DATA_W-1:0] payload_i,
  output logic              line_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frame_q <= '0;
    else if (!run_i)  frame_q <= '0;
    else if (wrap_i)  frame_q <= {CLOSE_LVL, payload_i, OPEN_LVL};
    else              frame_q <= {1'b0, frame_q[FRAME_W-1:1]};
  end

  assign line_o = frame_q[0];
endmodule

// File: rtl/ser_embed_clk.sv
module ser_embed_clk #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned READY_WORDS = 1024,
  parameter int unsigned SYNC_MIN    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              word_stb_i,
  input  logic              sync_i,
  input  logic              den_i,
  input  logic              pwr_ni,
  output logic              ser_o,
  output logic              oe_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned SW      = $clog2(FRAME_W);

  logic              wrap_w;
  logic [SW-1:0]     slot_w;
  logic              ready_w;
  logic              line_w;
  logic [DATA_W-1:0] payload_w;

  ser_bit_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk_i, .rst_ni, .run_i(pwr_ni), .wrap_o(wrap_w), .slot_o(slot_w)
  );

  ser_ready_timer #(.READY_WORDS(READY_WORDS)) u_ready (
    .clk_i, .rst_ni, .run_i(pwr_ni), .wrap_i(wrap_w), .ready_o(ready_w)
  );

  ser_payload_sel #(.DATA_W(DATA_W), .SYNC_MIN(SYNC_MIN)) u_pay (
    .clk_i, .rst_ni, .run_i(pwr_ni), .wrap_i(wrap_w), .stb_i(word_stb_i),
    .data_i, .sync_i, .payload_o(payload_w)
  );

  ser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .run_i(pwr_ni), .wrap_i(wrap_w),
    .payload_i(payload_w), .line_o(line_w)
  );

  assign oe_o  = ready_w && den_i && pwr_ni;
  assign ser_o = oe_o && line_w;
endmodule

// File: rtl/ser_embed_clk_chk.sv
module ser_embed_clk_chk #(
  parameter int unsigned DATA_W  = 18,
  parameter int unsigned FRAME_W = 20,
  localparam int unsigned SW = $clog2(FRAME_W),
  localparam logic [DATA_W-1:0] TRAIN =
    {{(DATA_W - DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}}
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_ni,
  input logic              sync_i,
  input logic              oe_o,
  input logic              ser_o,
  input logic              ready_i,
  input logic              wrap_i,
  input logic [SW-1:0]     slot_i,
  input logic              line_i,
  input logic [DATA_W-1:0] payload_i
);
  a_r1_open_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && pwr_ni && slot_i == '0) |-> line_i);

  a_r1_close_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && pwr_ni && slot_i == SW'(FRAME_W - 1)) |-> !line_i);

  a_r4_train_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && sync_i) |=> (!pwr_ni || payload_i == TRAIN));

  a_r7_pd_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ni |-> !oe_o);

  a_r8_wake_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_ni) |=> !oe_o);

  a_r9_line_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !ser_o);
endmodule

bind ser_embed_clk ser_embed_clk_chk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_ni(pwr_ni), .sync_i(sync_i),
  .oe_o(oe_o), .ser_o(ser_o), .ready_i(ready_w), .wrap_i(wrap_w),
  .slot_i(slot_w), .line_i(line_w), .payload_i(payload_w)
);

// File: tb/tb_ser_embed_clk.sv
`timescale 1ns/1ps
module tb_ser_embed_clk;
  localparam int DW = 18;
  localparam int FW = 20;
  localparam int WAIT_CYC = 1024 * FW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          word_stb_i = 1'b0;
  logic          sync_i = 1'b0;
  logic          den_i = 1'b1;
  logic          pwr_ni = 1'b1;
  logic          ser_o;
  logic          oe_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [FW-1:0] got, oem;
  logic [DW-1:0] hold_e, prev, w;
  int            nwait;

  always #10 clk_i = ~clk_i;

  ser_embed_clk dut (
    .clk_i, .rst_ni, .data_i, .word_stb_i, .sync_i, .den_i, .pwr_ni, .ser_o, .oe_o
  );

  function automatic logic [FW-1:0] fr(input logic [DW-1:0] p);
    return {1'b0, p, 1'b1};
  endfunction

  localparam logic [FW-1:0] TRN = {1'b0, 18'h001FF, 1'b1};

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // entered on the negedge showing slot 0; leaves on the next frame's slot 0
  task automatic read_frame(input logic stb, input logic [DW-1:0] d, input logic syn,
                            input logic den, output logic [FW-1:0] g, output logic [FW-1:0] m);
    for (int i = 0; i < FW; i++) begin
      g[i] = ser_o;
      m[i] = oe_o;
      if (i == 5) begin
        word_stb_i = stb; data_i = d; sync_i = syn; den_i = den;
      end
      if (i == 6) word_stb_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!oe_o && n < WAIT_CYC + 100);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8 reset oe", {19'd0, oe_o}, 20'd0);
    rst_ni = 1'b1;
    wait_ready(nwait);
    chk("R8 ready delay after reset", FW'(nwait), FW'(WAIT_CYC));

    read_frame(0, '0, 0, 1, got, oem);
    chk("R1 first frame", got, fr('0));
    chk("R1 oe full frame", oem, '1);

    // walking ones, walking zeros, and dense patterns
    prev = '0;
    for (int k = 0; k < 39; k++) begin
      if (k < 18)       w = DW'(1) << k;
      else if (k < 36)  w = ~(DW'(1) << (k - 18));
      else if (k == 36) w = 18'h2AAAA;
      else if (k == 37) w = 18'h15555;
      else              w = 18'h3FFFF;
      read_frame(1, w, 0, 1, got, oem);
      chk("R2 sweep", got, fr(prev));
      prev = w;
    end
    read_frame(0, '0, 0, 1, got, oem);
    chk("R3 next-frame latency", got, fr(prev));
    read_frame(0, '0, 0, 1, got, oem);
    chk("R3 repeat held word", got, fr(prev));
    hold_e = prev;

    // one-frame sync with a strobe that must be ignored
    read_frame(1, 18'h0F0F0, 1, 1, got, oem);
    chk("R4 frame before training", got, fr(hold_e));
    for (int j = 0; j < 6; j++) begin
      read_frame(0, '0, 0, 1, got, oem);
      chk("R5 short burst training", got, TRN);
    end
    read_frame(0, '0, 0, 1, got, oem);
    chk("R4 strobe during sync ignored", got, fr(hold_e));

    // sync held across three frame boundaries: 8 training frames
    read_frame(0, '0, 1, 1, got, oem);
    chk("R4 data before long sync", got, fr(hold_e));
    for (int j = 0; j < 8; j++) begin
      read_frame(0, '0, (j < 2), 1, got, oem);
      chk("R5 long burst training", got, TRN);
    end
    read_frame(0, '0, 0, 1, got, oem);
    chk("R5 data after long burst", got, fr(hold_e));

    // driver enable dropped and restored mid-frame
    read_frame(1, 18'h2C3A5, 0, 0, got, oem);
    chk("R6 partial frame line", got, fr(hold_e) & 20'h0003F);
    chk("R6 partial frame oe", oem, 20'h0003F);
    hold_e = 18'h2C3A5;
    read_frame(0, '0, 0, 0, got, oem);
    chk("R9 line quiet", got, '0);
    chk("R6 oe low", oem, '0);
    read_frame(0, '0, 0, 1, got, oem);
    chk("R6 resume on grid line", got, fr(hold_e) & 20'hFFFC0);
    chk("R6 resume oe", oem, 20'hFFFC0);
    read_frame(0, '0, 0, 1, got, oem);
    chk("R6 full frame after resume", got, fr(hold_e));

    // power-down with a strobe that must be ignored
    pwr_ni = 1'b0;
    @(negedge clk_i);
    chk("R7 oe off in power-down", {18'd0, oe_o, ser_o}, '0);
    word_stb_i = 1'b1; data_i = 18'h0AAAA;
    @(negedge clk_i);
    word_stb_i = 1'b0;
    repeat (30) @(negedge clk_i);
    chk("R7 oe stays off", {18'd0, oe_o, ser_o}, '0);
    pwr_ni = 1'b1;
    wait_ready(nwait);
    chk("R8 ready delay after power-down", FW'(nwait), FW'(WAIT_CYC));
    read_frame(0, '0, 0, 1, got, oem);
    chk("R7 held word kept, strobe ignored", got, fr(hold_e));
    chk("R1 oe full frame after wake", oem, '1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule